// File: doc/BRIEF.md
# Asynchronous DRAM access controller

This block sits between a simple synchronous host port and a 64K x 16 asynchronous DRAM. It turns one word request into one strobe sequence. The host raises `req` with the direction, a 16-bit word address, a two-bit byte mask and write data. It holds `req` high until `done` pulses.

The controller multiplexes the address onto an 8-bit pin bus. The upper address byte goes out first and is latched by the row strobe. The lower byte follows and is latched by the column strobe. There is one column strobe for each byte lane, and each one is gated by its bit of the mask, so single-byte reads and writes are possible. Every DRAM minimum is a parameter counted in clock cycles:

- row address setup
- RAS-to-column address switch
- column address setup
- column, OE and row access times
- RAS low width
- RAS and CAS precharge

The controller derives the length of the CAS-low window and of the precharge from these parameters.

An external refresh arbiter raises `refresh_busy` to keep the controller from starting new accesses. The data bus is split into `dq_out`, `dq_oe` and `dq_in`, so the tristate buffer stays at the chip pad.

Top module: `dram_ctrl`

## Requirements
- R1: In reset and while idle, all of the following hold:
  - `ras_n`, `lcas_n`, `ucas_n`, `we_n` and `oe_n` are high.
  - `dq_oe` is low.
  - `done` is low.
- R2: Before `ras_n` falls, `dram_addr` carries addr[15:8] for at least T_ASR cycles and keeps that value on the fall. It then switches to addr[7:0] and holds that value for at least T_ASC cycles up to and including the cycle in which the column strobes fall.
- R3: `lcas_n` (data bits 7:0) goes low only when be[0] is 1. `ucas_n` (data bits 15:8) goes low only when be[1] is 1. Enabled strobes fall in the same cycle and only while `ras_n` is low.
- R4: On a write (we=1), `we_n` goes low and `dq_oe` rises with wdata on `dq_out` at least one cycle before the column strobes fall. Both stay that way until the strobes rise. Only the enabled byte lanes of the addressed word are changed.
- R5: On a read (we=0), `we_n` stays high and `dq_oe` stays low for the whole cycle. `oe_n` falls together with the column strobes. `dq_in` is sampled at the end of a CAS-low window of max(T_CAC, T_OEA, T_RAC-T_RCD-T_ASC, T_RAS-T_RCD-T_ASC) cycles. Bytes of `rdata` whose `be` bit is 0 read as zero.
- R6: Each time `ras_n` goes low it stays low for at least T_RAS cycles.
- R7: Between the end of one cycle and the next fall of `ras_n`, both `ras_n` and the column strobes stay high for at least max(T_RP, T_CP) cycles.
- R8: `done` is a one-cycle pulse. It is high in the first cycle after the column strobes and `ras_n` return high. That cycle comes exactly T_RCD+T_ASC+(CAS-low window) cycles after the first cycle with `ras_n` low. `rdata` is valid from that cycle on.
- R9: While the controller is idle and `refresh_busy` is high, a pending `req` is not accepted and `ras_n` stays high.
- R10: `we`, `addr`, `be` and `wdata` are captured on acceptance. Changes to them after acceptance do not affect the running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until done |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Word address, row in [15:8], column in [7:0] |
| be | input | 2 | Byte-lane mask, bit 0 = data[7:0], bit 1 = data[15:8] |
| wdata | input | 16 | Write data |
| refresh_busy | input | 1 | Blocks acceptance of new requests |
| rdata | output | 16 | Read data, disabled lanes zero |
| done | output | 1 | One-cycle completion pulse |
| dram_addr | output | 8 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-lane column strobe, active low |
| ucas_n | output | 1 | Upper-lane column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | 16 | Data driven toward the DRAM |
| dq_oe | output | 1 | Enable for the data-bus driver |
| dq_in | input | 16 | Data returned from the DRAM |

## Verification
The bench DRAM model drives valid read data only after the row, column and OE access ages have all matured. A controller that samples one cycle early therefore returns the model's filler pattern instead of the stored word.

Single-lane writes are followed by full-word reads at the same address. This exposes a strobe that ignores its mask bit, because a neighbouring byte would be overwritten. Masked reads expose missing zeroing of the idle lane.

The host inputs are inverted right after acceptance. A controller that forwards live inputs instead of captured ones puts a wrong column or wrong data on the pins. Requests are also held against `refresh_busy`, and back-to-back accesses check the RAS low width and precharge spacing, so a shortened window shows up as a timing violation in the model.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;
    localparam int MUX_W  = ADDR_W / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PRE
    } seq_state_t;

    typedef struct packed {
        logic              wr;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic [MUX_W-1:0]  ma;
        logic              ras_n;
        logic [LANES-1:0]  cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } pin_t;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Length of the CAS-low window: every access time must have matured
    // and the RAS low width must be covered before the strobes rise.
    function automatic int cas_window(int t_rcd, int t_asc, int t_cac,
                                      int t_oea, int t_rac, int t_ras);
        int w;
        w = imax(t_cac, t_oea);
        w = imax(w, t_rac - t_rcd - t_asc);
        w = imax(w, t_ras - t_rcd - t_asc);
        return imax(w, 1);
    endfunction

endpackage

// File: rtl/dram_tmr.sv
module dram_tmr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dram_req_latch.sv
module dram_req_latch
    import dram_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sample,
    input  logic [DATA_W-1:0] dq_in,
    output host_req_t         req_q,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (capture) begin
            req_q.wr    <= wr_i;
            req_q.be    <= be_i;
            req_q.addr  <= addr_i;
            req_q.wdata <= wdata_i;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[i*LANE_W +: LANE_W] <= '0;
            end else if (sample) begin
                rdata[i*LANE_W +: LANE_W] <= req_q.be[i] ? dq_in[i*LANE_W +: LANE_W]
                                                         : '0;
            end
        end
    end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_ctrl_pkg::*;
#(
    parameter int D_ROW = 1,
    parameter int D_RAS = 2,
    parameter int D_COL = 1,
    parameter int D_CAS = 3,
    parameter int D_PRE = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          refresh_busy,
    input  logic          zero,
    output seq_state_t    state,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          capture,
    output logic          sample,
    output logic          done,
    output logic          idle
);
    seq_state_t nxt;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        sample   = 1'b0;
        unique case (state)
            ST_IDLE: if (req && !refresh_busy) begin
                nxt      = ST_ROW;
                load     = 1'b1;
                load_val = CW'(D_ROW - 1);
                capture  = 1'b1;
            end
            ST_ROW: if (zero) begin
                nxt      = ST_RAS;
                load     = 1'b1;
                load_val = CW'(D_RAS - 1);
            end
            ST_RAS: if (zero) begin
                nxt      = ST_COL;
                load     = 1'b1;
                load_val = CW'(D_COL - 1);
            end
            ST_COL: if (zero) begin
                nxt      = ST_CAS;
                load     = 1'b1;
                load_val = CW'(D_CAS - 1);
            end
            ST_CAS: if (zero) begin
                nxt      = ST_PRE;
                load     = 1'b1;
                load_val = CW'(D_PRE - 1);
                sample   = 1'b1;
            end
            ST_PRE: if (zero) begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= sample;
        end
    end

    assign idle = (state == ST_IDLE);
endmodule

// File: rtl/dram_pins.sv
module dram_pins
    import dram_ctrl_pkg::*;
(
    input  seq_state_t        state,
    input  host_req_t         req_q,
    output pin_t              pins,
    output logic [DATA_W-1:0] dq_out
);
    logic ras_low, col_phase, strobe_phase;

    assign ras_low      = (state == ST_RAS) || (state == ST_COL) || (state == ST_CAS);
    assign col_phase    = (state == ST_COL) || (state == ST_CAS);
    assign strobe_phase = (state == ST_CAS);

    always_comb begin
        pins.ma    = col_phase ? req_q.addr[MUX_W-1:0] : req_q.addr[ADDR_W-1:MUX_W];
        pins.ras_n = !ras_low;
        for (int i = 0; i < LANES; i++) begin
            pins.cas_n[i] = !(strobe_phase && req_q.be[i]);
        end
        pins.we_n  = !(col_phase && req_q.wr);
        pins.dq_oe = col_phase && req_q.wr;
        pins.oe_n  = !(strobe_phase && !req_q.wr);
    end

    assign dq_out = req_q.wdata;
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int T_ASR = 1,
    parameter int T_RCD = 2,
    parameter int T_ASC = 1,
    parameter int T_CAC = 2,
    parameter int T_OEA = 2,
    parameter int T_RAC = 5,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int T_CP  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              refresh_busy,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              lcas_n,
    output logic              ucas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int D_CAS  = cas_window(T_RCD, T_ASC, T_CAC, T_OEA, T_RAC, T_RAS);
    localparam int D_PRE  = imax(imax(T_RP, T_CP), 1);
    localparam int D_MAX  = imax(imax(imax(T_ASR, T_RCD), imax(T_ASC, D_CAS)), D_PRE);
    localparam int TMR_W  = $clog2(D_MAX + 1);

    seq_state_t       state;
    host_req_t        req_q;
    pin_t             pins;
    logic             load, zero, capture, sample, idle;
    logic [TMR_W-1:0] load_val;

    dram_tmr #(.CW(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    dram_seq #(
        .D_ROW (T_ASR),
        .D_RAS (T_RCD),
        .D_COL (T_ASC),
        .D_CAS (D_CAS),
        .D_PRE (D_PRE),
        .CW    (TMR_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .refresh_busy (refresh_busy),
        .zero         (zero),
        .state        (state),
        .load         (load),
        .load_val     (load_val),
        .capture      (capture),
        .sample       (sample),
        .done         (done),
        .idle         (idle)
    );

    dram_req_latch u_lat (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .wr_i    (we),
        .addr_i  (addr),
        .be_i    (be),
        .wdata_i (wdata),
        .sample  (sample),
        .dq_in   (dq_in),
        .req_q   (req_q),
        .rdata   (rdata)
    );

    dram_pins u_pins (
        .state  (state),
        .req_q  (req_q),
        .pins   (pins),
        .dq_out (dq_out)
    );

    assign dram_addr = pins.ma;
    assign ras_n     = pins.ras_n;
    assign lcas_n    = pins.cas_n[0];
    assign ucas_n    = pins.cas_n[1];
    assign we_n      = pins.we_n;
    assign oe_n      = pins.oe_n;
    assign dq_oe     = pins.dq_oe;
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int T_CP  = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       lcas_n,
    input logic       ucas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       dq_oe,
    input logic       done,
    input logic [7:0] dram_addr,
    input logic       idle,
    input logic       refresh_busy
);
    localparam int T_PRE = (T_RP > T_CP) ? T_RP : T_CP;
    localparam int SAT   = 255;

    int lo_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= 0;
            hi_cnt <= SAT;
        end else begin
            lo_cnt <= ras_n ? 0 : ((lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt);
            hi_cnt <= (!ras_n || !lcas_n || !ucas_n) ? 0
                      : ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt);
        end
    end

    assert_row_stable_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $stable(dram_addr));

    assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (rst)
        (!lcas_n || !ucas_n) |-> !ras_n);

    assert_we_leads_cas_R4: assert property (@(posedge clk) disable iff (rst)
        (($fell(lcas_n) || $fell(ucas_n)) && !we_n) |-> !$past(we_n));

    assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!dq_oe && we_n));

    assert_ras_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (lo_cnt >= T_RAS));

    assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= T_PRE));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_refresh_block_R9: assert property (@(posedge clk) disable iff (rst)
        (idle && refresh_busy) |=> idle);
endmodule

bind dram_ctrl dram_ctrl_chk #(
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .T_CP  (T_CP)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ras_n        (ras_n),
    .lcas_n       (lcas_n),
    .ucas_n       (ucas_n),
    .we_n         (we_n),
    .oe_n         (oe_n),
    .dq_oe        (dq_oe),
    .done         (done),
    .dram_addr    (dram_addr),
    .idle         (idle),
    .refresh_busy (refresh_busy)
);

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;
    localparam int T_ASR = 1, T_RCD = 2, T_ASC = 1, T_CAC = 2, T_OEA = 2;
    localparam int T_RAC = 5, T_RAS = 6, T_RP = 3, T_CP = 1;

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CASW  = mx(mx(mx(T_CAC, T_OEA), T_RAC - T_RCD - T_ASC), T_RAS - T_RCD - T_ASC);
    localparam int TPRE  = mx(T_RP, T_CP);
    localparam int D_LAT = T_RCD + T_ASC + CASW;

    logic clk = 0, rst = 1;
    logic req = 0, we = 0, refresh_busy = 0;
    logic [15:0] addr = 0, wdata = 0, dq_in = 16'h5A5A;
    logic [1:0]  be = 0;
    logic [15:0] rdata, dq_out;
    logic [7:0]  dram_addr;
    logic done, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;

    dram_ctrl dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
        .wdata(wdata), .refresh_busy(refresh_busy), .rdata(rdata), .done(done),
        .dram_addr(dram_addr), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // behavioural DRAM and host-side shadow
    logic [15:0] mem    [int unsigned];
    logic [15:0] shadow [int unsigned];

    function automatic logic [15:0] mem_rd(logic [15:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction
    function automatic logic [15:0] sh_rd(logic [15:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    logic        exp_wr = 0;
    logic [15:0] exp_addr = 0, exp_wdata = 0;
    logic [1:0]  exp_be = 0;

    logic p_ras = 1, p_lcas = 1, p_ucas = 1, p_we = 1, p_dqoe = 0, p_oe = 1, p_done = 0;
    logic [7:0]  p_addr = 0, row_l = 0;
    logic [15:0] p_dqout = 0;
    int ras_age = 0, cas_age = 0, oe_age = 0, hi_cnt = 100, cyc = 0, ras_fall_cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            p_ras = 1; p_lcas = 1; p_ucas = 1; p_we = 1; p_dqoe = 0; p_oe = 1; p_done = 0;
            hi_cnt = 100; ras_age = 0; cas_age = 0; oe_age = 0;
        end else begin
            bit cas_low, cas_fell;
            cas_low  = !lcas_n || !ucas_n;
            cas_fell = cas_low && p_lcas && p_ucas;
            if (!ras_n && p_ras) begin
                check(dram_addr == p_addr, "R2", "row held before RAS fall", {24'h0, dram_addr}, {24'h0, p_addr});
                check(dram_addr == exp_addr[15:8], "R2", "row value", {24'h0, dram_addr}, {24'h0, exp_addr[15:8]});
                check(hi_cnt >= TPRE, "R7", "precharge cycles", hi_cnt, TPRE);
                row_l = dram_addr; ras_age = 1; ras_fall_cyc = cyc;
            end else if (!ras_n) ras_age++;
            if (ras_n && !p_ras)
                check(ras_age >= T_RAS, "R6", "RAS low cycles", ras_age, T_RAS);
            if (ras_n && !cas_low) hi_cnt++; else hi_cnt = 0;
            if (cas_low) begin
                check(!ras_n, "R3", "CAS only under RAS", {31'h0, ras_n}, 0);
                check((lcas_n || exp_be[0]) && (ucas_n || exp_be[1]), "R3", "strobe vs mask",
                      {30'h0, ucas_n, lcas_n}, {30'h0, ~exp_be});
            end
            if (cas_fell) begin
                logic [15:0] w;
                check(lcas_n == !exp_be[0] && ucas_n == !exp_be[1], "R3", "lanes fall together",
                      {30'h0, ucas_n, lcas_n}, {30'h0, ~exp_be});
                check(dram_addr == p_addr && dram_addr == exp_addr[7:0], "R2", "column setup",
                      {24'h0, dram_addr}, {24'h0, exp_addr[7:0]});
                cas_age = 1;
                if (!we_n) begin
                    check(!p_we && p_dqoe && p_dqout == exp_wdata, "R4", "write setup before CAS",
                          {p_dqout, 14'h0, p_we, p_dqoe}, {exp_wdata, 16'h0001});
                    w = mem_rd({row_l, dram_addr});
                    if (!lcas_n) w[7:0]  = dq_out[7:0];
                    if (!ucas_n) w[15:8] = dq_out[15:8];
                    mem[{row_l, dram_addr}] = w;
                end
            end else if (cas_low) cas_age++;
            if (!oe_n && p_oe) oe_age = 1; else if (!oe_n) oe_age++;
            if (!exp_wr && !ras_n)
                check(!dq_oe && we_n, "R5", "bus undriven on read", {30'h0, dq_oe, we_n}, 32'h1);
            if (exp_wr && cas_low)
                check(!we_n && dq_oe && oe_n, "R4", "write held under CAS", {29'h0, we_n, dq_oe, oe_n}, 32'h3);
            // data appears only when every access time has matured
            if (!oe_n && cas_low && ras_age >= T_RAC && cas_age >= T_CAC && oe_age >= T_OEA) begin
                logic [15:0] m;
                m = mem_rd({row_l, p_addr});
                dq_in = {ucas_n ? 8'hA5 : m[15:8], lcas_n ? 8'hA5 : m[7:0]};
            end else dq_in = 16'h5A5A;
            if (done) begin
                check(cyc - ras_fall_cyc == D_LAT, "R8", "done latency", cyc - ras_fall_cyc, D_LAT);
                check(ras_n && lcas_n && ucas_n, "R8", "strobes high at done", {29'h0, ras_n, lcas_n, ucas_n}, 32'h7);
                check(!p_done, "R8", "single-cycle done", {31'h0, p_done}, 0);
            end
            p_ras = ras_n; p_lcas = lcas_n; p_ucas = ucas_n; p_we = we_n; p_dqoe = dq_oe;
            p_oe = oe_n; p_done = done; p_addr = dram_addr; p_dqout = dq_out;
        end
    end

    task automatic access(bit wr, logic [15:0] a, logic [1:0] b, logic [15:0] wd, int hold);
        exp_wr = wr; exp_addr = a; exp_be = b; exp_wdata = wd;
        if (hold > 0) refresh_busy = 1;
        req = 1; we = wr; addr = a; be = b; wdata = wd;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(ras_n && !done, "R9", "no access while refresh busy", {30'h0, ras_n, done}, 32'h2);
        end
        refresh_busy = 0;
        do @(negedge clk); while (ras_n);
        addr = ~a; wdata = ~wd; be = ~b;   // R10: later input changes must not matter
        do @(negedge clk); while (!done);
        req = 0;
        if (wr) begin
            logic [15:0] s;
            s = sh_rd(a);
            if (b[0]) s[7:0]  = wd[7:0];
            if (b[1]) s[15:8] = wd[15:8];
            shadow[a] = s;
            check(mem_rd(a) == s, "R4", "stored word, lanes masked", {16'h0, mem_rd(a)}, {16'h0, s});
            check(mem_rd(~a) == sh_rd(~a), "R10", "scrambled address untouched", {16'h0, mem_rd(~a)}, {16'h0, sh_rd(~a)});
        end else begin
            logic [15:0] e, s;
            s = sh_rd(a);
            e = {b[1] ? s[15:8] : 8'h00, b[0] ? s[7:0] : 8'h00};
            check(rdata == e, "R5", "read data", {16'h0, rdata}, {16'h0, e});
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(ras_n && lcas_n && ucas_n && we_n && oe_n && !dq_oe && !done, "R1", "reset pins",
              {25'h0, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe, done}, 32'h7C);
        rst = 0;
        repeat (3) @(negedge clk);
        check(ras_n && lcas_n && ucas_n && we_n && oe_n && !dq_oe && !done, "R1", "idle pins",
              {25'h0, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe, done}, 32'h7C);
        access(1, 16'h1234, 2'b11, 16'hBEEF, 0);
        access(0, 16'h1234, 2'b11, 16'h0, 0);
        access(1, 16'h1234, 2'b01, 16'h77AA, 0);
        access(0, 16'h1234, 2'b11, 16'h0, 0);
        access(1, 16'h1234, 2'b10, 16'h3C00, 0);
        access(0, 16'h1234, 2'b11, 16'h0, 0);
        access(0, 16'h1234, 2'b01, 16'h0, 0);
        access(0, 16'h1234, 2'b10, 16'h0, 0);
        access(1, 16'h0000, 2'b11, 16'h0101, 0);
        access(1, 16'hFFFF, 2'b11, 16'hFEFE, 0);
        access(1, 16'h00FF, 2'b11, 16'h1111, 0);
        access(1, 16'hFF00, 2'b11, 16'h2222, 20);
        access(0, 16'h0000, 2'b11, 16'h0, 0);
        access(0, 16'hFFFF, 2'b11, 16'h0, 7);
        access(0, 16'h00FF, 2'b11, 16'h0, 0);
        access(0, 16'hFF00, 2'b11, 16'h0, 0);
        for (int k = 0; k < 24; k++) begin
            logic [15:0] a;
            a = 16'(k * 16'h1F3 + 16'h0421);
            access(1, a, 2'(k % 3 + 1), 16'(k * 16'h3A97 + 16'h55), 0);
            access(0, a, 2'b11, 16'h0, 0);
        end
        repeat (5) @(negedge clk);
        check(ras_n && !dq_oe && !done, "R1", "idle after traffic", {29'h0, ras_n, dq_oe, done}, 32'h4);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule